// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Frame Filter

This block receives asynchronous serial characters of five to nine data bits and hands each finished character to the surrounding logic as a parallel word with a one-cycle valid strobe and a frame-error flag. The line is sampled at 16 times the bit rate in normal speed, or at 8 times the bit rate in double speed. Each bit is decided by a majority vote of three samples around its centre. The oversampling tick comes from a down-counter that reloads from a programmable divisor.

A filter mode supports several receivers that share one bus. Each character carries a frame-type bit. For five to eight data bits, this bit is the first stop bit. For nine data bits, it is the ninth data bit. A frame-type bit of one marks an address character and zero marks a data character. When the filter is on, data characters are discarded without a strobe. Software checks the address it receives and then turns the filter off, so that the data characters that follow are accepted.

Top module: `addrFilterRx`

## Requirements
- R1: After reset, rxValid, frameErr and rxBit9 are 0 and rxData is 0.
- R2: charSel selects the character size: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits, and any value with bit 2 set gives 9 data bits. Data bits arrive LSB first. rxData holds the low data bits right-aligned, and every bit of rxData above the character size reads 0.
- R3: For 9-bit characters, the ninth data bit appears on rxBit9. For smaller sizes, rxBit9 is 0 with every strobe.
- R4: With mpMode at 1, a character whose frame-type bit is 0 gives no rxValid strobe and leaves rxData unchanged.
- R5: With mpMode at 1, a character whose frame-type bit is 1 is delivered. The frame-type bit is the first stop bit for 5 to 8 data bits and the ninth data bit for 9 data bits.
- R6: With mpMode at 0, every character is delivered whatever its frame-type bit, and frameErr equals the inverse of the sampled stop bit.
- R7: With mpMode at 1 and 5 to 8 data bits, a zero stop bit only drops the character, so no strobe carries frameErr=1. A 9-bit address character with a zero stop bit is delivered with frameErr=1.
- R8: With dblSpeed at 1, a bit lasts 8 oversample ticks instead of 16.
- R9: One oversample tick occurs every baudDiv+1 clock cycles, and a normal-speed bit lasts 16 ticks.
- R10: A low pulse on the idle line that is gone before the start-bit centre is ignored. The receiver returns to idle and correctly receives the next character.
- R11: In normal speed, a 5-bit character whose bit period is off by about ±3% from the nominal rate is received correctly.
- R12: rxValid is high for exactly one clock cycle per delivered character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial input line, idle high |
| charSel | input | 3 | Character size select (R2 encoding) |
| mpMode | input | 1 | Address-frame filter enable |
| dblSpeed | input | 1 | Double-speed select (8x oversampling) |
| baudDiv | input | DIV_W (12) | Oversample tick divisor, period baudDiv+1 clocks |
| rxData | output | 8 | Received data bits, right-aligned |
| rxBit9 | output | 1 | Ninth data bit of a 9-bit character |
| rxValid | output | 1 | One-cycle strobe for a delivered character |
| frameErr | output | 1 | Stop bit sampled low, valid with rxValid |

## Verification
The bench switches the filter on and off and sends characters of every size with both frame-type values. A receiver that read the frame-type bit from the wrong place would deliver dropped data characters, or lose address characters, and the scoreboard would see extra or missing entries. Nine-bit address characters with a bad stop bit are sent to check that frameErr survives filtering, while a dropped short character must never show an error. Short glitches, double speed, a smaller divisor and bit periods about 3% slow and fast are also tried. A receiver that skipped the start-bit recheck, counted the wrong ticks per bit or sampled off-centre would shift or lose characters.

// File: rtl/addrFilterRx_pkg.sv
package addrFilterRx_pkg;
  localparam int DATA_MAX = 9;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;   // take one oversample into the vote window
    logic shift;    // voted data bit ready
    logic finish;   // voted stop bit ready, frame complete
  } rxStrobe_t;

  function automatic logic [CNT_W-1:0] charBits(input logic [2:0] sel);
    return sel[2] ? CNT_W'(9) : CNT_W'(5) + {2'b00, sel[1:0]};
  endfunction
endpackage

// File: rtl/rxBaudGen.sv
module rxBaudGen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (cnt == '0) cnt <= baudDiv;
    else                cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/rxControl.sv
module rxControl
  import addrFilterRx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      lineBit,
  input  logic      vote,
  input  logic      dblSpeed,
  input  logic [2:0] charSel,
  output rxStrobe_t strb
);
  rxState_t         state;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] bitIdx;
  logic [CNT_W-1:0] lastPh;
  logic [CNT_W-1:0] mid;
  logic [CNT_W-1:0] nBits;
  logic             evalNow;
  logic             inWin;

  assign lastPh  = dblSpeed ? CNT_W'(7) : CNT_W'(15);
  assign mid     = dblSpeed ? CNT_W'(4) : CNT_W'(8);
  assign nBits   = charBits(charSel);
  assign inWin   = (phase == mid - 1'b1) || (phase == mid) || (phase == mid + 1'b1);
  assign evalNow = tick && (state != ST_IDLE) && (phase == mid + CNT_W'(2));

  always_comb begin
    strb        = '0;
    strb.sample = tick && (state != ST_IDLE) && inWin;
    strb.shift  = evalNow && (state == ST_DATA);
    strb.finish = evalNow && (state == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (!lineBit) begin
          state <= ST_START;
          phase <= CNT_W'(1);
        end
      end else if (evalNow && state == ST_START && vote) begin
        state <= ST_IDLE;   // glitch, start bit did not hold
        phase <= '0;
      end else if (evalNow && state == ST_STOP) begin
        state <= ST_IDLE;
        phase <= '0;
      end else if (phase >= lastPh) begin
        phase <= '0;
        if (state == ST_START) begin
          state  <= ST_DATA;
          bitIdx <= '0;
        end else if (state == ST_DATA) begin
          if (bitIdx == nBits - 1'b1) state <= ST_STOP;
          else                        bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxDatapath.sv
module rxDatapath
  import addrFilterRx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  rxStrobe_t  strb,
  input  logic       mpMode,
  input  logic [2:0] charSel,
  output logic       lineBit,
  output logic       vote,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxValid,
  output logic       frameErr
);
  logic [1:0]          syncQ;
  logic [2:0]          sampleQ;
  logic [DATA_MAX-1:0] shiftQ;
  logic [DATA_MAX-1:0] word;
  logic [CNT_W-1:0]    nBits;
  logic                nine;
  logic                ftBit;
  logic                keep;

  assign lineBit = syncQ[1];
  assign vote    = (sampleQ[0] & sampleQ[1]) | (sampleQ[0] & sampleQ[2]) |
                   (sampleQ[1] & sampleQ[2]);
  assign nBits   = charBits(charSel);
  assign nine    = charSel[2];
  assign word    = shiftQ >> (CNT_W'(DATA_MAX) - nBits);
  assign ftBit   = nine ? word[DATA_MAX-1] : vote;
  assign keep    = !mpMode || ftBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      sampleQ <= 3'b111;
      shiftQ  <= '0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (strb.sample) sampleQ <= {sampleQ[1:0], lineBit};
      if (strb.shift)  shiftQ  <= {vote, shiftQ[DATA_MAX-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid  <= 1'b0;
      rxData   <= '0;
      rxBit9   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxValid <= strb.finish && keep;
      if (strb.finish && keep) begin
        rxData   <= word[7:0];
        rxBit9   <= nine & word[DATA_MAX-1];
        frameErr <= !vote;
      end
    end
  end
endmodule

// File: rtl/addrFilterRx.sv
module addrFilterRx
  import addrFilterRx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [2:0]       charSel,
  input  logic             mpMode,
  input  logic             dblSpeed,
  input  logic [DIV_W-1:0] baudDiv,
  output logic [7:0]       rxData,
  output logic             rxBit9,
  output logic             rxValid,
  output logic             frameErr
);
  logic      baudTick;
  logic      lineBit;
  logic      vote;
  rxStrobe_t strb;

  rxBaudGen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .tick(baudTick)
  );

  rxControl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(baudTick), .lineBit(lineBit),
    .vote(vote), .dblSpeed(dblSpeed), .charSel(charSel), .strb(strb)
  );

  rxDatapath u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strb(strb), .mpMode(mpMode),
    .charSel(charSel), .lineBit(lineBit), .vote(vote), .rxData(rxData),
    .rxBit9(rxBit9), .rxValid(rxValid), .frameErr(frameErr)
  );
endmodule

// File: rtl/addrFilterRx_chk.sv
module addrFilterRx_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] charSel,
  input logic       mpMode,
  input logic [7:0] rxData,
  input logic       rxBit9,
  input logic       rxValid,
  input logic       frameErr
);
  // R12
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7
  short_filter_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(mpMode) && !$past(charSel[2])) |-> !frameErr);

  // R5
  nine_filter_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(mpMode) && $past(charSel[2])) |-> rxBit9);

  // R3
  short_no_bit9_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !$past(charSel[2])) |-> !rxBit9);

  // R2
  five_bit_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(charSel) == 3'd0) |-> (rxData[7:5] == 3'b000));
endmodule

bind addrFilterRx addrFilterRx_chk u_chk (
  .clk(clk), .rstN(rstN), .charSel(charSel), .mpMode(mpMode),
  .rxData(rxData), .rxBit9(rxBit9), .rxValid(rxValid), .frameErr(frameErr)
);

// File: tb/addrFilterRx_bench.sv
module addrFilterRx_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [2:0]  charSel = 3'd3;
  logic        mpMode = 1'b0;
  logic        dblSpeed = 1'b0;
  logic [11:0] baudDiv = 12'd3;
  logic [7:0]  rxData;
  logic        rxBit9;
  logic        rxValid;
  logic        frameErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] d;
    logic       b9;
    logic       fe;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  addrFilterRx u_addrFilterRx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .charSel(charSel),
    .mpMode(mpMode), .dblSpeed(dblSpeed), .baudDiv(baudDiv),
    .rxData(rxData), .rxBit9(rxBit9), .rxValid(rxValid), .frameErr(frameErr)
  );

  // monitor: pop and compare every delivered character
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid) begin
        checks++;
        if (rxValid) begin
          failures++;
          $display("FAIL R12 rxValid width: actual=1 expected=0 on second cycle");
        end
      end
      if (rxValid) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R4 unexpected character: actual data=%h b9=%b expected none",
                   rxData, rxBit9);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (rxData !== e.d || rxBit9 !== e.b9 || frameErr !== e.fe) begin
            failures++;
            $display("FAIL %s: actual data=%h b9=%b fe=%b expected data=%h b9=%b fe=%b",
                     e.tag, rxData, rxBit9, frameErr, e.d, e.b9, e.fe);
          end
        end
      end
      prevValid <= rxValid;
    end
  end

  task automatic driveBit(input logic v, input int clks);
    rxLine = v;
    repeat (clks) @(negedge clk);
  endtask

  // driver: push expectation, then serialize the frame
  task automatic sendFrame(input int n, input logic [8:0] d, input logic stopV,
                           input int bitClks, input string tag);
    logic [8:0] m;
    logic       ft;
    exp_t       e;
    m  = d & ((9'h1 << n) - 9'h1);
    ft = (n == 9) ? m[8] : stopV;
    charSel = (n == 9) ? 3'd4 : 3'(n - 5);
    if (!mpMode || ft) begin
      e.d = m[7:0]; e.b9 = (n == 9) ? m[8] : 1'b0; e.fe = !stopV; e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    driveBit(1'b0, bitClks);
    for (int i = 0; i < n; i++) driveBit(m[i], bitClks);
    driveBit(stopV, bitClks);
    driveBit(1'b1, 2 * bitClks);
  endtask

  task automatic expectDrained(input string tag);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s pending characters: actual=%0d expected=0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;  // R1
    if (rxValid !== 1'b0 || frameErr !== 1'b0 || rxBit9 !== 1'b0 || rxData !== 8'h00) begin
      failures++;
      $display("FAIL R1 reset state: actual v=%b fe=%b b9=%b d=%h expected 0 0 0 00",
               rxValid, frameErr, rxBit9, rxData);
    end
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R2 R3 R6 R9: filter off, normal speed, tick every 4 clocks -> 64 clocks/bit
    sendFrame(8, 9'h0A5, 1'b1, 64, "R2 8-bit");
    sendFrame(5, 9'h1F3, 1'b1, 64, "R2 5-bit");
    sendFrame(6, 9'h02D, 1'b1, 64, "R2 6-bit");
    sendFrame(7, 9'h155, 1'b1, 64, "R2 7-bit");
    sendFrame(9, 9'h1C3, 1'b1, 64, "R3 9-bit");
    sendFrame(9, 9'h03C, 1'b1, 64, "R3 9-bit low ninth");
    sendFrame(8, 9'h05A, 1'b0, 64, "R6 bad stop delivered");
    sendFrame(9, 9'h011, 1'b0, 64, "R6 9-bit bad stop");
    expectDrained("R6");

    // R4 R5 R7: filter on
    mpMode = 1'b1;
    sendFrame(8, 9'h042, 1'b1, 64, "R5 8-bit address");
    sendFrame(8, 9'h099, 1'b0, 64, "R4 8-bit data dropped");
    sendFrame(9, 9'h077, 1'b1, 64, "R4 9-bit data dropped");
    sendFrame(9, 9'h1E1, 1'b1, 64, "R5 9-bit address");
    sendFrame(9, 9'h1B4, 1'b0, 64, "R7 9-bit address bad stop");
    sendFrame(7, 9'h033, 1'b0, 64, "R7 7-bit dropped no error");
    sendFrame(5, 9'h00C, 1'b1, 64, "R5 5-bit address");
    checks++;  // R4: last dropped frame must not have changed rxData
    if (rxData !== 8'h0C) begin
      failures++;
      $display("FAIL R4 rxData after drops: actual=%h expected=0c", rxData);
    end
    expectDrained("R4");

    // R6: filter cleared, data characters pass
    mpMode = 1'b0;
    sendFrame(8, 9'h0C7, 1'b0, 64, "R6 data after address");
    sendFrame(8, 9'h0E8, 1'b1, 64, "R6 data stop high");

    // R8: double speed, 8 ticks per bit -> 32 clocks/bit
    dblSpeed = 1'b1;
    sendFrame(8, 9'h06E, 1'b1, 32, "R8 double speed 8-bit");
    sendFrame(9, 9'h18B, 1'b1, 32, "R8 double speed 9-bit");
    dblSpeed = 1'b0;

    // R9: divisor 1 -> tick every 2 clocks -> 32 clocks/bit
    baudDiv = 12'd1;
    repeat (20) @(negedge clk);
    sendFrame(8, 9'h0D2, 1'b1, 32, "R9 divisor 1");
    baudDiv = 12'd3;
    repeat (20) @(negedge clk);

    // R10: glitch shorter than half a bit
    charSel = 3'd3;
    driveBit(1'b0, 12);
    driveBit(1'b1, 200);
    expectDrained("R10 glitch");
    sendFrame(8, 9'h081, 1'b1, 64, "R10 frame after glitch");

    // R11: about +/-3% bit period error
    sendFrame(5, 9'h015, 1'b1, 66, "R11 slow 5-bit");
    sendFrame(5, 9'h00A, 1'b1, 62, "R11 fast 5-bit");
    repeat (100) @(negedge clk);
    expectDrained("R11");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule